// File: doc/BRIEF.md
# Embedded-Boundary Serial Deserializer

This block turns a serial bit stream, sent together with its own bit clock, back into 24-bit parallel words. No separate frame line exists: the start of a word is marked on the clock/data pair itself. The data line changes while the bit clock is high, which is the phase in which data is normally held steady. The block oversamples both serial lines with the system clock. It shifts in payload bits on bit-clock rising edges and moves a completed word to the parallel output when the next boundary arrives. It then shapes a parallel strobe whose timing is counted in serial bit times.

A frame holds 24 payload bits and two framing positions. When the sending side's reference clock runs faster than its word rate, non-valid filler bits follow the frame. Everything after the 24th payload bit is discarded, so the strobe period follows the word rate. The output is a plain register that is overwritten at each accepted word. There is no valid/ready handshake and no back-pressure: a consumer must take the word during the strobe low time, before the next accepted boundary replaces it. A direction input selects receive mode when it is low.

Top module: `deser_embedded_rx`

## Requirements
- R1: While `dir_i` is high the block is not receiving: bits and boundaries are ignored, `pdata_o` holds its value, and `pstrobe_o` stays high.
- R2: A word boundary is detected when `sdat_i` changes while `sclk_i` stays high across two consecutive samples. A boundary returns the bit position to the first payload bit.
- R3: Payload bits are taken on `sclk_i` rising edges, least significant first. The first bit after a boundary lands in `pdata_o[0]` and the 24th in `pdata_o[23]`.
- R4: `pdata_o` changes only at a boundary that follows at least 24 payload bits. Bits after the 24th (framing positions 25 and 26 and any filler) never reach the output.
- R5: A boundary that follows fewer than 24 bits loads nothing and starts no strobe pulse.
- R6: After a boundary that loads a word, `pstrobe_o` falls on the 6th `sclk_i` rising edge after that boundary.
- R7: Once low, `pstrobe_o` stays low for 13 `sclk_i` rising edges and returns high on the 13th.
- R8: With no word-loading boundary, `pstrobe_o` stays high.
- R9: A boundary that arrives while a strobe delay or low time is in progress restarts the timing. `pstrobe_o` goes high and falls again on the 6th rising edge after the new boundary.
- R10: After reset, `pdata_o` is all zeros and `pstrobe_o` is high. `pdata_o` stays zero until the first complete word is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous reset, active high |
| dir_i | input | 1 | Direction control; low selects receive |
| sclk_i | input | 1 | Forwarded serial bit clock |
| sdat_i | input | 1 | Serial data |
| pdata_o | output | 24 | Parallel word, LSB received first |
| pstrobe_o | output | 1 | Parallel strobe, active-low pulse per word |

## Verification
The bench builds the block with its default values: a 24-bit word, a 6-bit-time strobe delay and a 13-bit-time low time. These values let a full frame with framing bits and filler, and a complete strobe pulse, be checked bit-exactly in a few hundred serial bits. The 4-bit timer reaches both its delay terminal and its low-time terminal. The default word length also leaves room for a 20-bit truncated frame and for a boundary that lands inside the low time. The table of words with different filler counts exercises the discard of bits beyond the 24th.

// File: rtl/deser_pkg.sv
package deser_pkg;
  // strobe shaping phases
  typedef enum logic [1:0] {
    STB_IDLE = 2'd0,
    STB_WAIT = 2'd1,
    STB_LOW  = 2'd2
  } stb_state_e;
endpackage

// File: rtl/deser_sampler.sv
module deser_sampler (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic sclk_i,
  input  logic sdat_i,
  output logic rise_o,
  output logic bnd_o,
  output logic bit_o
);
  logic sclk_q, sclk_d, sdat_q, sdat_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      sclk_d <= 1'b0;
      sdat_q <= 1'b0;
      sdat_d <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      sclk_d <= sclk_q;
      sdat_q <= sdat_i;
      sdat_d <= sdat_q;
    end
  end

  // rising edge of the bit clock: take a bit
  assign rise_o = en & sclk_q & ~sclk_d;
  // data moved while the clock stayed high: boundary marker
  assign bnd_o  = en & sclk_q & sclk_d & (sdat_q ^ sdat_d);
  assign bit_o  = sdat_q;
endmodule

// File: rtl/deser_shifter.sv
module deser_shifter #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         rise_i,
  input  logic         bnd_i,
  input  logic         bit_i,
  output logic         load_o,
  output logic [W-1:0] pdata_o
);
  localparam int unsigned CW = $clog2(W + 2);
  localparam logic [CW-1:0] FULL    = CW'(W);
  localparam logic [CW-1:0] UNALIGN = CW'(W + 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  sh;

  // a boundary closes the word only if all payload bits arrived
  assign load_o = bnd_i & (cnt == FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= UNALIGN;
      sh  <= '0;
    end else if (!en) begin
      cnt <= UNALIGN;
    end else if (bnd_i) begin
      cnt <= '0;
    end else if (rise_i && (cnt < FULL)) begin
      sh[cnt] <= bit_i;
      cnt     <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         pdata_o <= '0;
    else if (load_o) pdata_o <= sh;
  end
endmodule

// File: rtl/deser_strobe.sv
module deser_strobe
  import deser_pkg::*;
#(
  parameter int unsigned DLY  = 6,
  parameter int unsigned LOWT = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic rise_i,
  input  logic start_i,
  input  logic bnd_i,
  output logic strobe_o
);
  localparam int unsigned MAXT = (DLY > LOWT) ? DLY : LOWT;
  localparam int unsigned TW   = $clog2(MAXT + 1);
  localparam logic [TW-1:0] DLY_END = TW'(DLY - 1);
  localparam logic [TW-1:0] LOW_END = TW'(LOWT - 1);

  stb_state_e    st;
  logic [TW-1:0] t;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st <= STB_IDLE;
      t  <= '0;
    end else if (start_i || (bnd_i && st != STB_IDLE)) begin
      st <= STB_WAIT;
      t  <= '0;
    end else if (rise_i) begin
      unique case (st)
        STB_WAIT: begin
          if (t == DLY_END) begin
            st <= STB_LOW;
            t  <= '0;
          end else begin
            t <= t + 1'b1;
          end
        end
        STB_LOW: begin
          if (t == LOW_END) begin
            st <= STB_IDLE;
            t  <= '0;
          end else begin
            t <= t + 1'b1;
          end
        end
        default: t <= '0;
      endcase
    end
  end

  assign strobe_o = (st != STB_LOW);
endmodule

// File: rtl/deser_embedded_rx.sv
module deser_embedded_rx #(
  parameter int unsigned W    = 24,
  parameter int unsigned DLY  = 6,
  parameter int unsigned LOWT = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dir_i,
  input  logic         sclk_i,
  input  logic         sdat_i,
  output logic [W-1:0] pdata_o,
  output logic         pstrobe_o
);
  logic rx_en;
  logic s_rise, s_bnd, s_bit, s_load;

  assign rx_en = ~dir_i;

  deser_sampler u_samp (
    .clk(clk), .rst(rst), .en(rx_en), .sclk_i(sclk_i), .sdat_i(sdat_i),
    .rise_o(s_rise), .bnd_o(s_bnd), .bit_o(s_bit)
  );

  deser_shifter #(.W(W)) u_shift (
    .clk(clk), .rst(rst), .en(rx_en), .rise_i(s_rise), .bnd_i(s_bnd),
    .bit_i(s_bit), .load_o(s_load), .pdata_o(pdata_o)
  );

  deser_strobe #(.DLY(DLY), .LOWT(LOWT)) u_stb (
    .clk(clk), .rst(rst), .en(rx_en), .rise_i(s_rise), .start_i(s_load),
    .bnd_i(s_bnd), .strobe_o(pstrobe_o)
  );
endmodule

// File: rtl/deser_embedded_rx_chk.sv
module deser_embedded_rx_chk #(
  parameter int unsigned W = 24
) (
  input logic         clk,
  input logic         rst,
  input logic         dir_i,
  input logic [W-1:0] pdata_o,
  input logic         pstrobe_o,
  input logic         s_bnd,
  input logic         s_rise
);
  assert_reset_state_R10: assert property (@(posedge clk)
    rst |=> (pdata_o == '0 && pstrobe_o));

  assert_dir_hold_data_R1: assert property (@(posedge clk) disable iff (rst)
    dir_i |=> $stable(pdata_o));

  assert_dir_strobe_high_R1: assert property (@(posedge clk) disable iff (rst)
    dir_i |=> pstrobe_o);

  assert_load_at_boundary_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(pdata_o) |-> $past(s_bnd));

  assert_fall_on_bit_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(pstrobe_o) |-> $past(s_rise));

  assert_rise_on_bit_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(pstrobe_o) |-> ($past(s_rise) || $past(s_bnd)));
endmodule

bind deser_embedded_rx deser_embedded_rx_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .dir_i(dir_i), .pdata_o(pdata_o),
  .pstrobe_o(pstrobe_o), .s_bnd(s_bnd), .s_rise(s_rise)
);

// File: tb/deser_embedded_rx_bench.sv
module deser_embedded_rx_bench;
  localparam int W = 24;
  localparam int NV = 6;
  // {filler count, word}
  localparam logic [31:0] VEC [NV] = '{
    {8'd0, 24'hA5C3E1},
    {8'd3, 24'h000001},
    {8'd7, 24'h800000},
    {8'd1, 24'hFFFFFF},
    {8'd12, 24'h123456},
    {8'd2, 24'h5A5A5A}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dir_i = 1'b0;
  logic sclk_i = 1'b0;
  logic sdat_i = 1'b0;
  logic [W-1:0] pdata_o;
  logic pstrobe_o;
  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  deser_embedded_rx u_deser_embedded_rx (
    .clk(clk), .rst(rst), .dir_i(dir_i), .sclk_i(sclk_i), .sdat_i(sdat_i),
    .pdata_o(pdata_o), .pstrobe_o(pstrobe_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    sclk_i = 1'b0;
    sdat_i = b;
    repeat (2) @(negedge clk);
    sclk_i = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_bits(input int n);
    for (int i = 0; i < n; i++) send_bit(i[0]);
  endtask

  // data toggles while the bit clock is held high
  task automatic send_bnd();
    @(negedge clk);
    sclk_i = 1'b0;
    repeat (2) @(negedge clk);
    sclk_i = 1'b1;
    @(negedge clk);
    sdat_i = ~sdat_i;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_word(input logic [W-1:0] w, input int nfill);
    for (int i = 0; i < W; i++) send_bit(w[i]);
    send_bit(1'b1);
    send_bit(1'b0);
    for (int i = 0; i < nfill; i++) send_bit(~i[0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(pdata_o == '0, "R10 reset data", 32'(pdata_o), 0);
    chk(pstrobe_o == 1'b1, "R10 reset strobe", 32'(pstrobe_o), 1);

    // table walk: each boundary loads the previous word
    for (int i = 0; i < NV; i++) begin
      send_bnd();
      if (i == 0)
        chk(pdata_o == '0, "R10 zero before first word", 32'(pdata_o), 0);
      else
        chk(pdata_o == VEC[i-1][23:0], "R3 R4 word load", 32'(pdata_o),
            32'(VEC[i-1][23:0]));
      send_word(VEC[i][23:0], int'(VEC[i][31:24]));
    end
    send_bnd();
    chk(pdata_o == VEC[NV-1][23:0], "R2 R4 last word", 32'(pdata_o),
        32'(VEC[NV-1][23:0]));

    // strobe shape after the loading boundary above
    send_bits(5);
    chk(pstrobe_o == 1'b1, "R6 high before 6th rise", 32'(pstrobe_o), 1);
    send_bits(1);
    chk(pstrobe_o == 1'b0, "R6 low at 6th rise", 32'(pstrobe_o), 0);
    send_bits(12);
    chk(pstrobe_o == 1'b0, "R7 low through 12 rises", 32'(pstrobe_o), 0);
    send_bits(1);
    chk(pstrobe_o == 1'b1, "R7 high at 13th rise", 32'(pstrobe_o), 1);

    // restart inside the low time
    send_bnd();
    send_word(24'h0F0F0F, 0);
    send_bnd();
    send_bits(8);
    chk(pstrobe_o == 1'b0, "R6 low before restart", 32'(pstrobe_o), 0);
    send_bnd();
    chk(pstrobe_o == 1'b1, "R9 high after restart", 32'(pstrobe_o), 1);
    chk(pdata_o == 24'h0F0F0F, "R5 short word keeps data", 32'(pdata_o), 32'h0F0F0F);
    send_bits(5);
    chk(pstrobe_o == 1'b1, "R9 high before 6th rise", 32'(pstrobe_o), 1);
    send_bits(1);
    chk(pstrobe_o == 1'b0, "R9 low at 6th rise", 32'(pstrobe_o), 0);
    send_bits(14);
    // 20 bits since boundary: truncated word
    send_bnd();
    chk(pdata_o == 24'h0F0F0F, "R5 truncated word dropped", 32'(pdata_o), 32'h0F0F0F);
    send_bits(8);
    chk(pstrobe_o == 1'b1, "R5 R8 no pulse for truncated", 32'(pstrobe_o), 1);

    // direction high: nothing received
    dir_i = 1'b1;
    send_bnd();
    send_word(24'h333333, 1);
    send_bnd();
    send_bits(8);
    chk(pdata_o == 24'h0F0F0F, "R1 data held", 32'(pdata_o), 32'h0F0F0F);
    chk(pstrobe_o == 1'b1, "R1 strobe high", 32'(pstrobe_o), 1);
    dir_i = 1'b0;
    send_bnd();
    send_word(24'hC0FFEE, 4);
    send_bnd();
    chk(pdata_o == 24'hC0FFEE, "R1 receive resumes", 32'(pdata_o), 32'hC0FFEE);

    // reset mid-pulse
    send_bits(7);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(pdata_o == '0, "R10 reset clears data", 32'(pdata_o), 0);
    chk(pstrobe_o == 1'b1, "R10 reset strobe high", 32'(pstrobe_o), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule